// File: doc/BRIEF.md
# Program Counter with Jump Modes

This block holds the fetch address of a small accumulator-based processor and chooses the next address on every clock. With no redirect requested, it counts up by one, so a plain fetch needs no separate increment step. Three redirect forms sit on top of the count. A page jump replaces only the low byte with an 8-bit payload taken from the instruction. An indirect jump copies the whole accumulator into the counter. A long jump takes two cycles. In the first it steps onto the word that follows the jump instruction. In the second it loads that word once memory signals it is ready.

While a long jump waits for its operand, a busy output tells the decoder to stall. During that wait the jump-kind input has no effect. Reset is synchronous and active-low. Instruction decoding, the ALU and the memory itself belong to neighbouring blocks.

Top module: `pc_jump_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next `fetch_addr` is 0x0000 and `busy` is low.
- R2: With `jmp_kind` = 2'b00 (advance) and `busy` low, `fetch_addr` grows by exactly one per clock.
- R3: Advancing from 0xFFFF gives 0x0000, with no other output change.
- R4: With `jmp_kind` = 2'b01 (page jump) and `busy` low, the next `fetch_addr` keeps its upper byte and takes `payload` as its lower byte.
- R5: With `jmp_kind` = 2'b11 (indirect) and `busy` low, the next `fetch_addr` equals `acc`; for example, `acc` = 0x0100 gives 0x0100.
- R6: With `jmp_kind` = 2'b10 (long jump) and `busy` low, the next `fetch_addr` is the current one plus one, and `busy` rises.
- R7: When `busy` and `mem_ready` are both high, the next `fetch_addr` equals `mem_word`, and `busy` falls.
- R8: When `busy` is high and `mem_ready` is low, `fetch_addr` holds its value and `busy` stays high.
- R9: While `busy` is high, `jmp_kind`, `payload` and `acc` have no effect on `fetch_addr` or `busy`.
- R10: Reset wins over every other request, including a pending long-jump operand load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jmp_kind | input | 2 | Redirect request: 00 advance, 01 page, 10 long, 11 indirect |
| payload | input | 8 | Low-byte target for a page jump |
| mem_word | input | 16 | Word fetched after a long-jump instruction |
| acc | input | 16 | Accumulator value for an indirect jump |
| mem_ready | input | 1 | Memory has valid data on `mem_word` |
| fetch_addr | output | 16 | Current fetch address |
| busy | output | 1 | High while a long jump waits for its operand |

## Verification
The hardest state to reach from the ports is a long jump whose operand cycle runs long. The counter must sit frozen while the decoder keeps offering other jump kinds, and a reset can strike in the middle of that wait. The stimulus reaches it by issuing a long jump and then holding `mem_ready` low for several cycles with page and indirect requests on `jmp_kind`. It then releases `mem_ready`, and in a later run asserts reset while an operand is pending. A long stretch of random kinds and ready strobes then walks through the other orderings against the bench's own model.

// File: rtl/pcj_pkg.sv
// Package: shared types for the program counter and its jump logic.
// Assumes: the jump-kind encoding matches the decoder's two-bit field.
package pcj_pkg;

    // Redirect request coming from the instruction decoder
    typedef enum logic [1:0] {
        JK_ADVANCE  = 2'b00,
        JK_PAGE     = 2'b01,
        JK_LONG     = 2'b10,
        JK_INDIRECT = 2'b11
    } jump_kind_t;

    // Source selected for the next counter value
    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_OPERAND,
        SRC_HOLD,
        SRC_INDIRECT,
        SRC_PAGE,
        SRC_STEP
    } pc_src_t;

endpackage

// File: rtl/pcj_long_seq.sv
// Module: pcj_long_seq
// Tracks the operand cycle of a long jump. busy rises after a long jump
// is accepted and falls after the cycle in which mem_ready is seen.
// Assumes: reset is synchronous and active-low.
module pcj_long_seq
    import pcj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  jump_kind_t kind,
    input  logic       mem_ready,
    output logic       busy
);

    logic busy_q;

    // Purpose: enter the operand wait on a long jump, leave it when memory is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            busy_q <= !mem_ready;
        end else begin
            busy_q <= (kind == JK_LONG);
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/pcj_src_arb.sv
// Module: pcj_src_arb
// Picks the source of the next counter value by fixed priority:
// reset, operand load, indirect, page, then step.
// Assumes: busy comes from pcj_long_seq; a pending operand blocks every redirect.
module pcj_src_arb
    import pcj_pkg::*;
(
    input  logic       rst_n,
    input  logic       busy,
    input  logic       mem_ready,
    input  jump_kind_t kind,
    output pc_src_t    src
);

    // Purpose: priority choice of the next-address source
    always_comb begin
        if (!rst_n) begin
            src = SRC_ZERO;
        end else if (busy) begin
            src = mem_ready ? SRC_OPERAND : SRC_HOLD;
        end else begin
            unique case (kind)
                JK_INDIRECT: src = SRC_INDIRECT;
                JK_PAGE:     src = SRC_PAGE;
                default:     src = SRC_STEP;
            endcase
        end
    end

endmodule

// File: rtl/pcj_next_mux.sv
// Module: pcj_next_mux
// Forms the next counter value from the chosen source.
// Assumes: PAGE_W <= ADDR_W; a page jump keeps the bits above PAGE_W.
module pcj_next_mux
    import pcj_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  pc_src_t           src,
    input  logic [ADDR_W-1:0] pc,
    input  logic [PAGE_W-1:0] payload,
    input  logic [ADDR_W-1:0] mem_word,
    input  logic [ADDR_W-1:0] acc,
    output logic [ADDR_W-1:0] pc_next
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] page_target;
    logic [ADDR_W-1:0] step_target;

    // Purpose: page target keeps the upper part when one exists
    generate
        if (HI_W > 0) begin : g_split_page
            assign page_target = {pc[ADDR_W-1:PAGE_W], payload};
        end else begin : g_full_page
            assign page_target = payload;
        end
    endgenerate

    // Purpose: plain advance, wrapping at the top of the address space
    assign step_target = pc + 1'b1;

    // Purpose: select the next counter value
    always_comb begin
        unique case (src)
            SRC_ZERO:     pc_next = '0;
            SRC_OPERAND:  pc_next = mem_word;
            SRC_HOLD:     pc_next = pc;
            SRC_INDIRECT: pc_next = acc;
            SRC_PAGE:     pc_next = page_target;
            default:      pc_next = step_target;
        endcase
    end

endmodule

// File: rtl/pc_jump_unit.sv
// Module: pc_jump_unit
// Program counter with advance, page, long and indirect jump forms.
// Assumes: the decoder stalls while busy is high; mem_word is valid
// whenever mem_ready is high.
module pc_jump_unit
    import pcj_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        jmp_kind,
    input  logic [PAGE_W-1:0] payload,
    input  logic [ADDR_W-1:0] mem_word,
    input  logic [ADDR_W-1:0] acc,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              busy
);

    jump_kind_t        kind;
    pc_src_t           src;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_next;

    // Purpose: give the raw request field its enumerated type
    assign kind = jump_kind_t'(jmp_kind);

    pcj_long_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .mem_ready (mem_ready),
        .busy      (busy)
    );

    pcj_src_arb u_arb (
        .rst_n     (rst_n),
        .busy      (busy),
        .mem_ready (mem_ready),
        .kind      (kind),
        .src       (src)
    );

    pcj_next_mux #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_mux (
        .src      (src),
        .pc       (pc_q),
        .payload  (payload),
        .mem_word (mem_word),
        .acc      (acc),
        .pc_next  (pc_next)
    );

    // Purpose: the counter register itself
    always_ff @(posedge clk) begin
        pc_q <= pc_next;
    end

    assign fetch_addr = pc_q;

endmodule

// File: rtl/pcj_checker.sv
// Module: pcj_checker
// Port-level properties of pc_jump_unit, bound to every instance.
// Assumes: jump encoding 00 advance, 01 page, 10 long, 11 indirect.
module pcj_checker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        jmp_kind,
    input logic [PAGE_W-1:0] payload,
    input logic [ADDR_W-1:0] mem_word,
    input logic [ADDR_W-1:0] acc,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              busy
);

    // R2 R3
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jmp_kind == 2'b00) |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)) && !busy);

    // R4
    page_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jmp_kind == 2'b01) |=>
            (fetch_addr[PAGE_W-1:0] == $past(payload)) &&
            (fetch_addr[ADDR_W-1:PAGE_W] == $past(fetch_addr[ADDR_W-1:PAGE_W])));

    // R5
    indirect_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jmp_kind == 2'b11) |=> (fetch_addr == $past(acc)) && !busy);

    // R6
    long_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jmp_kind == 2'b10) |=> busy && (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

    // R7
    operand_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_ready) |=> !busy && (fetch_addr == $past(mem_word)));

    // R8 R9
    operand_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> busy && $stable(fetch_addr));

endmodule

bind pc_jump_unit pcj_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_pcj_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .jmp_kind   (jmp_kind),
    .payload    (payload),
    .mem_word   (mem_word),
    .acc        (acc),
    .mem_ready  (mem_ready),
    .fetch_addr (fetch_addr),
    .busy       (busy)
);

// File: tb/pc_jump_unit_tb.sv
// Bench: behavioural reference model of the counter, compared every clock.
module pc_jump_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  jmp_kind = 2'b00;
    logic [7:0]  payload = 8'h00;
    logic [15:0] mem_word = 16'h0000;
    logic [15:0] acc = 16'h0000;
    logic        mem_ready = 1'b0;
    logic [15:0] fetch_addr;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [15:0] m_pc;
    logic        m_busy;

    always #2.5 clk = ~clk;

    pc_jump_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .jmp_kind   (jmp_kind),
        .payload    (payload),
        .mem_word   (mem_word),
        .acc        (acc),
        .mem_ready  (mem_ready),
        .fetch_addr (fetch_addr),
        .busy       (busy)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // One cycle: drive, let the edge pass, update the model, compare at the falling edge
    task automatic step(input logic r, input logic [1:0] k, input logic [7:0] p,
                        input logic [15:0] w, input logic [15:0] a, input logic rdy,
                        input string tag);
        rst_n = r; jmp_kind = k; payload = p; mem_word = w; acc = a; mem_ready = rdy;
        @(posedge clk);
        if (!r) begin
            m_pc = 16'h0000; m_busy = 1'b0;
        end else if (m_busy) begin
            if (rdy) begin
                m_pc = w; m_busy = 1'b0;
            end
        end else begin
            case (k)
                2'b11: m_pc = a;
                2'b01: m_pc = {m_pc[15:8], p};
                2'b10: begin m_pc = m_pc + 16'd1; m_busy = 1'b1; end
                default: m_pc = m_pc + 16'd1;
            endcase
        end
        @(negedge clk);
        checks = checks + 1;
        if (fetch_addr !== m_pc || busy !== m_busy) begin
            fails = fails + 1;
            $display("FAIL %s: actual addr=%h busy=%b expected addr=%h busy=%b",
                     tag, fetch_addr, busy, m_pc, m_busy);
        end
    endtask

    initial begin
        m_pc = 16'h0000; m_busy = 1'b0;
        @(negedge clk);
        // R1 reset state
        step(1'b0, 2'b11, 8'h55, 16'hAAAA, 16'h7777, 1'b1, "R1");
        step(1'b0, 2'b00, 8'h00, 16'h0000, 16'h0000, 1'b0, "R1");
        // R2 plain advance
        for (int i = 0; i < 5; i++) step(1'b1, 2'b00, 8'hFF, 16'hFFFF, 16'hFFFF, 1'b1, "R2");
        // R5 indirect, 0x0100 example
        step(1'b1, 2'b11, 8'h00, 16'h0000, 16'h0100, 1'b0, "R5");
        // R4 page jump keeps upper byte
        step(1'b1, 2'b01, 8'h3C, 16'h0000, 16'h0000, 1'b0, "R4");
        step(1'b1, 2'b00, 8'h00, 16'h0000, 16'h0000, 1'b0, "R2");
        // R3 wrap at the top
        step(1'b1, 2'b11, 8'h00, 16'h0000, 16'hFFFE, 1'b0, "R5");
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 8'h00, 16'h0000, 16'h0000, 1'b0, "R3");
        // R6 long jump start
        step(1'b1, 2'b10, 8'h00, 16'h0000, 16'h0000, 1'b0, "R6");
        // R8 R9 wait with other requests offered
        step(1'b1, 2'b11, 8'h00, 16'h9999, 16'h4444, 1'b0, "R8");
        step(1'b1, 2'b01, 8'h77, 16'h9999, 16'h4444, 1'b0, "R9");
        step(1'b1, 2'b10, 8'h77, 16'h9999, 16'h4444, 1'b0, "R9");
        // R7 operand load, page request ignored (R9)
        step(1'b1, 2'b01, 8'hEE, 16'h1234, 16'h4444, 1'b1, "R7");
        step(1'b1, 2'b00, 8'h00, 16'h0000, 16'h0000, 1'b1, "R2");
        // R10 reset wins over a pending operand
        step(1'b1, 2'b10, 8'h00, 16'h0000, 16'h0000, 1'b0, "R6");
        step(1'b0, 2'b11, 8'h00, 16'h5678, 16'h2222, 1'b1, "R10");
        step(1'b1, 2'b00, 8'h00, 16'h5678, 16'h2222, 1'b1, "R10");
        // Mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            step(($urandom_range(0, 49) != 0), 2'($urandom_range(0, 3)), 8'($urandom),
                 16'($urandom), 16'($urandom), ($urandom_range(0, 2) == 0), "R9 mixed");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule